// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a single-port synchronous memory whose inputs and outputs both pass through registers. It accepts one command on every enabled clock edge, and reads and writes can follow each other in any order with no idle cycle between them. A write presents its address and byte selects first. Its data follows two enabled edges later. Read data leaves through an output register, so the host captures it at the second enabled edge after the read's address. Because read data and write data use the same bus slot, traffic can switch between reads and writes at full rate.

A write stays pending while its address moves through two internal stages, and it commits when its data arrives. If a read targets an address whose write is committing at the edge where the read takes its data, the read gets the incoming bytes for the lanes that write enables and the stored bytes for the other lanes. A low clock enable freezes the whole block. Commands come either from an external load or from a two-bit burst counter. The counter runs in linear or interleaved order, chosen when the burst is loaded.

Top module: `lw_sram`

## Requirements
- R1: A read sampled at enabled edge k raises `rdata_vld` and drives the stored word on `rdata` after enabled edge k+1, so the host captures it at edge k+2.
- R2: Any mix of reads and writes may be issued on consecutive enabled edges, and every read returns the data of all commands issued before it.
- R3: `bsel_n` is active low and bit b covers `wdata` bits [9b+8:9b]. A write changes only the bytes whose select is 0, and the other bytes keep their stored value.
- R4: The data of a write sampled at enabled edge k is taken from `wdata` at enabled edge k+2 and stored at the write's address.
- R5: A read issued on the enabled edge right after a write to the same address returns that write's enabled bytes, merged with the stored bytes for the lanes it does not enable.
- R6: After the enabled edge that follows a write's address edge, `rdata_vld` is 0 for the whole slot in which that write's data is on the bus.
- R7: At an edge with `clk_en` low nothing advances, nothing is committed and `wdata` is ignored. `rdata` and `rdata_vld` hold their values.
- R8: A command is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A load with any other combination is a deselect: it writes nothing, and one enabled edge later `rdata_vld` is 0.
- R9: With `adv`=0 a new command is loaded from `addr`, `wr` (1 = write) and the chip selects. With `adv`=1 the last loaded operation continues at the next burst address, the chip selects and `wr` are ignored, and `bsel_n` is sampled on every beat.
- R10: With `burst_ilv`=0 at the load, beat n of a burst uses low address bits (start + n) mod 4. The upper bits stay fixed.
- R11: With `burst_ilv`=1 at the load, beat n uses low address bits start XOR n. The upper bits stay fixed.
- R12: After reset `rdata_vld` and `rdata` are 0 and no command is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable, active high; low freezes the block |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load new command, 1 = advance burst |
| wr | input | 1 | 1 = write, 0 = read (sampled on loads) |
| bsel_n | input | BYTES | Byte write selects, active low |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| wdata | input | BYTES*BYTE_W | Write data, sampled two enabled edges after its address |
| rdata | output | BYTES*BYTE_W | Registered read data |
| rdata_vld | output | 1 | High while `rdata` carries read data |

## Verification
The bench builds the block with its defaults: 8 address bits, and four 9-bit lanes that form a 36-bit word. That is 256 words, few enough for the bench to fill all of them and read them back. The random phase keeps addresses within 16 words, so writes and reads of the same word often fall one edge apart. This hits the merge path with every byte-select pattern, and also bursts that wrap inside a four-word group. Stalls, deselects and burst continuations are mixed into the same traffic, so a frozen edge can fall between a write's address and its data.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  // low two address bits for beat number 'beat' of a burst starting at 'start'
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/lw_sram_cmd.sv
`timescale 1ns/1ps
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sel_ok,
  input  logic              adv,
  input  logic              wr,
  input  logic [BYTES-1:0]  bsel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_ilv,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [BYTES-1:0]  s1_be
);

  op_e               last_op, nxt_op;
  logic [ADDR_W-1:0] base_q, nxt_addr;
  logic [1:0]        beat_q, nxt_beat;
  logic              ilv_q;

  always_comb begin
    if (!adv) begin
      nxt_beat = 2'd0;
      nxt_addr = addr;
      nxt_op   = !sel_ok ? OP_NOP : (wr ? OP_WR : OP_RD);
    end else begin
      nxt_beat = beat_q + 2'd1;
      nxt_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], nxt_beat, ilv_q)};
      nxt_op   = last_op;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op <= OP_NOP;
      base_q  <= '0;
      beat_q  <= '0;
      ilv_q   <= 1'b0;
      s1_op   <= OP_NOP;
      s1_addr <= '0;
      s1_be   <= '0;
    end else if (clk_en) begin
      beat_q  <= nxt_beat;
      s1_op   <= nxt_op;
      s1_addr <= nxt_addr;
      s1_be   <= (nxt_op == OP_WR) ? ~bsel_n : '0;
      if (!adv) begin
        base_q  <= addr;
        ilv_q   <= burst_ilv;
        last_op <= nxt_op;
      end
    end
  end

endmodule

// File: rtl/lw_sram_wpipe.sv
`timescale 1ns/1ps
module lw_sram_wpipe
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  op_e               s1_op,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [BYTES-1:0]  s1_be,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [BYTES-1:0]  s2_be,
  output logic              commit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op   <= OP_NOP;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (clk_en) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  // the write in stage two meets its data at this enabled edge
  assign commit = clk_en && (s2_op == OP_WR);

endmodule

// File: rtl/lw_sram_array.sv
`timescale 1ns/1ps
module lw_sram_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [BYTES-1:0]          wbe,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [BYTES*BYTE_W-1:0]   wword,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [BYTES*BYTE_W-1:0]   rword
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[b]) bank[waddr] <= wword[b*BYTE_W +: BYTE_W];
    end

    assign rword[b*BYTE_W +: BYTE_W] = bank[raddr];
  end

endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic                     cs0_n,
  input  logic                     cs1,
  input  logic                     cs2_n,
  input  logic                     adv,
  input  logic                     wr,
  input  logic [BYTES-1:0]         bsel_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     burst_ilv,
  input  logic [BYTES*BYTE_W-1:0]  wdata,
  output logic [BYTES*BYTE_W-1:0]  rdata,
  output logic                     rdata_vld
);

  localparam int WORD_W = BYTES * BYTE_W;

  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] base,
                                                   input logic [WORD_W-1:0] upd,
                                                   input logic [BYTES-1:0]  take);
    logic [WORD_W-1:0] r;
    r = base;
    for (int b = 0; b < BYTES; b++)
      if (take[b]) r[b*BYTE_W +: BYTE_W] = upd[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic              sel_ok;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s1_be, s2_be, fwd_be;
  logic              commit, fwd_hit;
  logic [WORD_W-1:0] arr_word, rd_word;

  assign sel_ok = !cs0_n && cs1 && !cs2_n;

  lw_sram_cmd #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_ok(sel_ok), .adv(adv),
    .wr(wr), .bsel_n(bsel_n), .addr(addr), .burst_ilv(burst_ilv),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
  );

  lw_sram_wpipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_wpipe (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be), .commit(commit)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .we(commit), .wbe(s2_be), .waddr(s2_addr), .wword(wdata),
    .raddr(s1_addr), .rword(arr_word)
  );

  // a write committing at this edge to the read's address supplies its lanes
  assign fwd_hit = (s2_op == OP_WR) && (s2_addr == s1_addr);
  assign fwd_be  = fwd_hit ? s2_be : '0;
  assign rd_word = merge_word(arr_word, wdata, fwd_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else if (clk_en) begin
      rdata_vld <= (s1_op == OP_RD);
      if (s1_op == OP_RD) rdata <= rd_word;
    end
  end

endmodule

// File: rtl/lw_sram_chk.sv
`timescale 1ns/1ps
module lw_sram_chk
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              adv,
  input op_e               s1_op,
  input op_e               s2_op,
  input logic [ADDR_W-1:0] s1_addr,
  input logic [WORD_W-1:0] rdata,
  input logic              rdata_vld
);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(rdata) && $stable(rdata_vld) && $stable(s1_addr));

  // R6
  wr_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && (s1_op == OP_WR) |=> !rdata_vld);

  // R1
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && (s1_op == OP_RD) |=> rdata_vld);

  // R8
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && (s1_op == OP_NOP) |=> !rdata_vld);

  // R4
  wstage_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> s2_op == $past(s1_op));

  // R10
  burst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv |=> s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]));

  // R9
  burst_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv |=> s1_op == $past(s1_op));

endmodule

bind lw_sram lw_sram_chk #(.ADDR_W(ADDR_W), .WORD_W(BYTES*BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv(adv),
  .s1_op(s1_op), .s2_op(s2_op), .s1_addr(s1_addr),
  .rdata(rdata), .rdata_vld(rdata_vld)
);

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en, cs0_n, cs1, cs2_n, adv, wr, burst_ilv;
  logic [3:0]  bsel_n;
  logic [7:0]  addr;
  logic [35:0] wdata, rdata;
  logic        rdata_vld;

  lw_sram dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .adv(adv), .wr(wr), .bsel_n(bsel_n), .addr(addr),
    .burst_ilv(burst_ilv), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  logic [35:0] ref_mem [256];
  logic [35:0] wd_s1, wd_s2;
  int          m_op;           // 0 none, 1 read, 2 write
  logic [7:0]  m_base;
  int          m_beat;
  bit          m_ilv;
  bit          have_prev;
  int          p_op;
  logic [35:0] p_exp;
  string       p_tag;
  logic [35:0] hold_data;
  logic        hold_vld;

  function automatic logic [35:0] rnd36();
    return {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
  endfunction

  function automatic logic [35:0] apply_bytes(logic [35:0] old, logic [35:0] nw, logic [3:0] sel_n);
    logic [35:0] r = old;
    for (int b = 0; b < 4; b++)
      if (sel_n[b] == 1'b0) r[b*9 +: 9] = nw[b*9 +: 9];
    return r;
  endfunction

  function automatic logic [1:0] beat_bits(logic [1:0] s, int n, bit ilv);
    int v;
    if (ilv) v = int'(s) ^ (n % 4);
    else     v = (int'(s) + n) % 4;
    return v[1:0];
  endfunction

  task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock; called at a falling edge, returns at the next falling edge
  task automatic step(bit en, bit c0n, bit c1, bit c2n, bit a, bit w,
                      logic [3:0] bs, logic [7:0] ad, bit il,
                      logic [35:0] wd_new, string tag);
    int          op = 0;
    logic [7:0]  ea;
    logic [35:0] ex = '0;
    clk_en = en; cs0_n = c0n; cs1 = c1; cs2_n = c2n; adv = a; wr = w;
    bsel_n = bs; addr = ad; burst_ilv = il;
    wdata  = en ? wd_s2 : rnd36();
    if (en) begin
      if (!a) begin
        m_base = ad; m_beat = 0; m_ilv = il;
        m_op = (!c0n && c1 && !c2n) ? (w ? 2 : 1) : 0;
      end else begin
        m_beat = m_beat + 1;
      end
      ea = {m_base[7:2], beat_bits(m_base[1:0], m_beat, m_ilv)};
      op = m_op;
      ex = ref_mem[ea];
      if (op == 2) ref_mem[ea] = apply_bytes(ref_mem[ea], wd_new, bs);
    end
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      if (have_prev) begin
        if (p_op == 1) begin
          chk(rdata_vld == 1'b1, "R1 vld", {35'd0, rdata_vld}, 36'd1);
          chk(rdata == p_exp, p_tag, rdata, p_exp);
        end else if (p_op == 2) begin
          chk(rdata_vld == 1'b0, "R6", {35'd0, rdata_vld}, 36'd0);
        end else begin
          chk(rdata_vld == 1'b0, "R8 vld", {35'd0, rdata_vld}, 36'd0);
        end
      end
      have_prev = 1'b1;
      p_op = op; p_exp = ex; p_tag = tag;
      wd_s2 = wd_s1;
      wd_s1 = wd_new;
    end else begin
      chk(rdata == hold_data && rdata_vld == hold_vld, "R7 hold",
          rdata, hold_data);
    end
    hold_data = rdata;
    hold_vld  = rdata_vld;
  endtask

  task automatic ld(bit w, logic [7:0] ad, logic [3:0] bs, logic [35:0] d, string tag, bit il = 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, w, bs, ad, il, d, tag);
  endtask

  // burst advance: chip selects and wr are scrambled on purpose (R9)
  task automatic nx(logic [3:0] bs, logic [35:0] d, string tag);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, bs, 8'hFF, 1'b1, d, tag);
  endtask

  task automatic idle();
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 8'h00, 1'b0, rnd36(), "idle");
  endtask

  task automatic stall();
    step(1'b0, $urandom()%2, $urandom()%2, $urandom()%2, $urandom()%2, $urandom()%2,
         4'($urandom()), 8'($urandom()), $urandom()%2, rnd36(), "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [35:0] d1, d2;
    void'($urandom(32'h5eed_1234));
    have_prev = 0; m_op = 0; m_base = '0; m_beat = 0; m_ilv = 0;
    wd_s1 = '0; wd_s2 = '0;
    rst_n = 1'b0; clk_en = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
    adv = 1'b0; wr = 1'b0; bsel_n = 4'hF; addr = '0; burst_ilv = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(rdata_vld == 1'b0, "R12 vld", {35'd0, rdata_vld}, 36'd0);
    chk(rdata == 36'd0, "R12 data", rdata, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    hold_data = rdata; hold_vld = rdata_vld;

    // fill every word, then read all back (R4)
    for (int i = 0; i < 256; i++) ld(1'b1, 8'(i), 4'h0, rnd36(), "R6");
    for (int i = 0; i < 256; i++) ld(1'b0, 8'(i), 4'h0, rnd36(), "R4");

    // R5: read right behind a write to the same word, full and partial
    d1 = rnd36(); d2 = rnd36();
    ld(1'b1, 8'h20, 4'h0, d1, "R5");
    ld(1'b0, 8'h20, 4'h0, rnd36(), "R5");
    ld(1'b1, 8'h20, 4'b1010, d2, "R5");
    ld(1'b0, 8'h20, 4'h0, rnd36(), "R5");
    // R2: alternating traffic without gaps
    ld(1'b1, 8'h21, 4'h0, rnd36(), "R2");
    ld(1'b1, 8'h22, 4'h0, rnd36(), "R2");
    ld(1'b0, 8'h21, 4'h0, rnd36(), "R2");
    ld(1'b0, 8'h22, 4'h0, rnd36(), "R2");
    ld(1'b1, 8'h21, 4'h0, rnd36(), "R2");
    ld(1'b0, 8'h22, 4'h0, rnd36(), "R2");
    ld(1'b0, 8'h21, 4'h0, rnd36(), "R2");

    // R3: only byte lane 0 written; lanes 1..3 keep old content
    ld(1'b1, 8'h30, 4'h0, rnd36(), "R3");
    idle(); idle();
    ld(1'b1, 8'h30, 4'b1110, rnd36(), "R3");
    idle(); idle();
    ld(1'b0, 8'h30, 4'h0, rnd36(), "R3");
    ld(1'b1, 8'h31, 4'hF, rnd36(), "R3");
    idle(); idle();
    ld(1'b0, 8'h31, 4'h0, rnd36(), "R3");

    // R9: write burst continues with selects and wr scrambled
    ld(1'b1, 8'h43, 4'h0, rnd36(), "R9");
    nx(4'h0, rnd36(), "R9");
    nx(4'b0011, rnd36(), "R9");
    nx(4'h0, rnd36(), "R9");
    idle(); idle();
    for (int i = 0; i < 4; i++) ld(1'b0, 8'h40 + 8'(i), 4'h0, rnd36(), "R9");

    // R10: linear read burst with wrap from low bits 3
    ld(1'b0, 8'h4B, 4'h0, rnd36(), "R10", 1'b0);
    for (int i = 0; i < 3; i++) nx(4'h0, rnd36(), "R10");
    // R11: interleaved read burst from low bits 1 and 2
    ld(1'b0, 8'h55, 4'h0, rnd36(), "R11", 1'b1);
    for (int i = 0; i < 3; i++) nx(4'h0, rnd36(), "R11");
    ld(1'b0, 8'h5A, 4'h0, rnd36(), "R11", 1'b1);
    for (int i = 0; i < 3; i++) nx(4'h0, rnd36(), "R11");
    idle();

    // R7: stalls between a write address and its data, and while read data is out
    ld(1'b1, 8'h70, 4'h0, rnd36(), "R7");
    stall(); stall();
    ld(1'b0, 8'h70, 4'h0, rnd36(), "R7");
    stall();
    idle();
    stall(); stall();
    idle();

    // R8: each wrong chip-select combination drops a write
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 8'h60, 1'b0, rnd36(), "R8");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 8'h61, 1'b0, rnd36(), "R8");
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 8'h62, 1'b0, rnd36(), "R8");
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'h63, 1'b0, rnd36(), "R8");
    nx(4'h0, rnd36(), "R8");
    idle(); idle();
    for (int i = 0; i < 4; i++) ld(1'b0, 8'h60 + 8'(i), 4'h0, rnd36(), "R8");

    // R2: constrained random mix within 16 words
    for (int i = 0; i < 4000; i++) begin
      bit en  = ($urandom() % 8) != 0;
      bit a   = ($urandom() % 3) == 0;
      bit bad = ($urandom() % 10) == 0;
      step(en, bad ? 1'b1 : 1'b0, 1'b1, 1'b0, a, $urandom() % 2,
           4'($urandom()), 8'($urandom() % 16), $urandom() % 2, rnd36(), "R2");
    end
    idle(); idle(); idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule